// File: doc/BRIEF.md
# Accumulator Rotate and Nibble Exchange Unit

This unit carries out the single-operand and exchange operations on an 8-bit accumulator: plain rotates in both directions, rotates through the carry flag, a swap of the two 4-bit halves, a whole-byte exchange with an addressed operand, and an exchange of the low nibbles only. A start strobe captures the operation code, the accumulator, the carry flag and the operand byte. The unit then counts out the machine cycles that the operation class takes and presents the new accumulator, new carry and the byte to write back to the operand location, all registered on the final edge and marked by a one-clock done pulse.

Accumulator-only operations take one machine cycle. The two exchanges involve an addressed operand and take two. A machine cycle lasts `MC_CLKS` clocks. The data path is `DATA_W` bits wide, split into two nibbles of `DATA_W/2` bits.

Top module: `acc_rot_unit`

## Requirements
- R1: Operation code 0 (rotate left) gives a new accumulator whose bit 0 is the old bit 7 and whose bits 7:1 are the old bits 6:0.
- R2: Operation code 1 (rotate right) gives a new accumulator whose bit 7 is the old bit 0 and whose bits 6:0 are the old bits 7:1.
- R3: Code 2 (left through carry) puts the old carry in bit 0, old bits 6:0 in bits 7:1, and old bit 7 in the carry. Code 3 (right through carry) puts the old carry in bit 7, old bits 7:1 in bits 6:0, and old bit 0 in the carry.
- R4: Codes 0, 1 and 4 leave the carry output equal to the carry captured at start.
- R5: Code 4 (swap) gives a new accumulator with bits 7:4 and bits 3:0 exchanged.
- R6: Code 5 (full exchange) returns the captured operand as the new accumulator and the captured accumulator as the write-back byte, with the carry unchanged.
- R7: Code 6 (low-nibble exchange) exchanges bits 3:0 of the accumulator and the operand and keeps both upper nibbles, with the carry unchanged.
- R8: Code 7 returns the captured accumulator, carry and operand unchanged. Every operation other than codes 5 and 6 returns the captured operand as the write-back byte.
- R9: Done rises MC_CLKS clocks after the edge that accepts start for codes 0 to 4 and 7, and 2*MC_CLKS clocks after it for codes 5 and 6.
- R10: Done is high for exactly one clock. The three result outputs change only on the edge that raises done and hold their value otherwise.
- R11: A start that arrives while an operation is in progress is ignored. It does not alter the running operation or its timing.
- R12: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled while idle |
| op_i | input | 3 | Operation code (0 to 7, see requirements) |
| acc_i | input | DATA_W | Current accumulator |
| cy_i | input | 1 | Current carry flag |
| opnd_i | input | DATA_W | Addressed operand byte |
| acc_o | output | DATA_W | New accumulator |
| cy_o | output | 1 | New carry flag |
| opnd_o | output | DATA_W | Byte to write back to the operand location |
| done_o | output | 1 | One-clock pulse when the results are valid |

## Verification
A wrong cycle count in the sequencer shows up as done rising on the wrong clock. Because the results are registered together with done, every output also changes on that wrong clock, so the per-clock comparison catches the fault within one machine cycle of the expected end. A wrong capture or a wrong result path is seen at the ports on the single done edge of the operation concerned. A start that leaks in during a busy period corrupts the outputs of the operation already running, and that shows at the next done edge.

// File: rtl/acc_rot_pkg.sv
package acc_rot_pkg;
  typedef enum logic [2:0] {
    OP_RL   = 3'd0,
    OP_RR   = 3'd1,
    OP_RLC  = 3'd2,
    OP_RRC  = 3'd3,
    OP_SWAP = 3'd4,
    OP_XCH  = 3'd5,
    OP_XCHD = 3'd6,
    OP_NOP  = 3'd7
  } rot_op_e;

  function automatic logic is_two_mc(rot_op_e op);
    return (op == OP_XCH) || (op == OP_XCHD);
  endfunction
endpackage

// File: rtl/acc_rot_alu.sv
module acc_rot_alu
  import acc_rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rot_op_e             op_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic                cy_i,
  input  logic [DATA_W-1:0]   opnd_i,
  output logic [DATA_W-1:0]   acc_o,
  output logic                cy_o,
  output logic [DATA_W-1:0]   opnd_o
);
  localparam int NIB = DATA_W / 2;

  always_comb begin
    acc_o  = acc_i;
    cy_o   = cy_i;
    opnd_o = opnd_i;
    unique case (op_i)
      OP_RL:   acc_o = {acc_i[DATA_W-2:0], acc_i[DATA_W-1]};
      OP_RR:   acc_o = {acc_i[0], acc_i[DATA_W-1:1]};
      OP_RLC: begin
        acc_o = {acc_i[DATA_W-2:0], cy_i};
        cy_o  = acc_i[DATA_W-1];
      end
      OP_RRC: begin
        acc_o = {cy_i, acc_i[DATA_W-1:1]};
        cy_o  = acc_i[0];
      end
      OP_SWAP: acc_o = {acc_i[NIB-1:0], acc_i[DATA_W-1:NIB]};
      OP_XCH: begin
        acc_o  = opnd_i;
        opnd_o = acc_i;
      end
      OP_XCHD: begin
        acc_o  = {acc_i[DATA_W-1:NIB], opnd_i[NIB-1:0]};
        opnd_o = {opnd_i[DATA_W-1:NIB], acc_i[NIB-1:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_rot_timer.sv
module acc_rot_timer #(
  parameter int MC_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_mc_i,
  output logic accept_o,
  output logic busy_o,
  output logic fire_o
);
  localparam int MAX_CLKS = 2 * MC_CLKS;
  localparam int CW       = $clog2(MAX_CLKS + 1);

  logic [CW-1:0] remain_q;
  logic          two_mc_q;

  assign accept_o = start_i && !busy_o;
  assign fire_o   = busy_o && (remain_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      remain_q <= '0;
      two_mc_q <= 1'b0;
    end else if (accept_o) begin
      busy_o   <= 1'b1;
      two_mc_q <= two_mc_i;
      remain_q <= two_mc_i ? CW'(MAX_CLKS - 1) : CW'(MC_CLKS - 1);
    end else if (fire_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  // independent elapsed-clock counter for the cycle-count check
  logic [CW-1:0] elapsed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       elapsed_q <= '0;
    else if (accept_o) elapsed_q <= '0;
    else if (busy_o)   elapsed_q <= elapsed_q + 1'b1;
  end

  assert_mc_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> (int'(elapsed_q) == (two_mc_q ? MAX_CLKS - 1 : MC_CLKS - 1)));

  assert_busy_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !busy_o);
endmodule

// File: rtl/acc_rot_unit.sv
module acc_rot_unit
  import acc_rot_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MC_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              cy_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              cy_o,
  output logic [DATA_W-1:0] opnd_o,
  output logic              done_o
);
  rot_op_e           op_q;
  logic [DATA_W-1:0] acc_q, opnd_q, acc_n, opnd_n;
  logic              cy_q, cy_n;
  logic              accept, busy, fire;

  acc_rot_timer #(.MC_CLKS(MC_CLKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .two_mc_i (is_two_mc(rot_op_e'(op_i))),
    .accept_o (accept),
    .busy_o   (busy),
    .fire_o   (fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NOP;
      acc_q  <= '0;
      cy_q   <= 1'b0;
      opnd_q <= '0;
    end else if (accept) begin
      op_q   <= rot_op_e'(op_i);
      acc_q  <= acc_i;
      cy_q   <= cy_i;
      opnd_q <= opnd_i;
    end
  end

  acc_rot_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (op_q),
    .acc_i  (acc_q),
    .cy_i   (cy_q),
    .opnd_i (opnd_q),
    .acc_o  (acc_n),
    .cy_o   (cy_n),
    .opnd_o (opnd_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o  <= '0;
      cy_o   <= 1'b0;
      opnd_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fire;
      if (fire) begin
        acc_o  <= acc_n;
        cy_o   <= cy_n;
        opnd_o <= opnd_n;
      end
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(acc_o) && $stable(cy_o) && $stable(opnd_o)));

  assert_ignore_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> ($stable(op_q) && $stable(acc_q) && $stable(opnd_q)));

  assert_keep_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_RL || op_q == OP_RR || op_q == OP_SWAP))
      |-> (cy_o == cy_q && $countones(acc_o) == $countones(acc_q)));

  assert_thru_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_RLC || op_q == OP_RRC))
      |-> ($countones({acc_o, cy_o}) == $countones({acc_q, cy_q})));

  assert_exch_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_XCH || op_q == OP_XCHD))
      |-> (cy_o == cy_q && $countones({acc_o, opnd_o}) == $countones({acc_q, opnd_q})));

  assert_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_NOP)
      |-> (acc_o == acc_q && cy_o == cy_q && opnd_o == opnd_q));
endmodule

// File: tb/acc_rot_unit_test.sv
`timescale 1ns/1ps
module acc_rot_unit_test;
  localparam int MC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic       cy = 1'b0;
  logic [7:0] acc_o, opnd_o;
  logic       cy_o, done_o;

  always #2.5 clk = ~clk;

  acc_rot_unit #(.DATA_W(8), .MC_CLKS(MC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .acc_i(acc), .cy_i(cy), .opnd_i(opnd),
    .acc_o(acc_o), .cy_o(cy_o), .opnd_o(opnd_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference
  bit       m_busy, m_done, m_cy, c_cy;
  int       m_left;
  int       c_op;
  bit [7:0] m_acc, m_opnd, c_acc, c_opnd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0;
      m_acc = 0; m_opnd = 0; m_cy = 0; c_op = 7;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_left == 0) begin
          m_busy = 0; m_done = 1;
          m_acc = c_acc; m_cy = c_cy; m_opnd = c_opnd;
          case (c_op)
            0: m_acc = (c_acc << 1) | (c_acc >> 7);
            1: m_acc = (c_acc >> 1) | (c_acc << 7);
            2: begin m_acc = (c_acc << 1) | 8'(c_cy); m_cy = c_acc[7]; end
            3: begin m_acc = (c_acc >> 1) | (8'(c_cy) << 7); m_cy = c_acc[0]; end
            4: m_acc = (c_acc << 4) | (c_acc >> 4);
            5: begin m_acc = c_opnd; m_opnd = c_acc; end
            6: begin
              m_acc  = (c_acc & 8'hF0) | (c_opnd & 8'h0F);
              m_opnd = (c_opnd & 8'hF0) | (c_acc & 8'h0F);
            end
            default: ;
          endcase
        end else m_left--;
      end else if (start) begin
        m_busy = 1; c_op = int'(op); c_acc = acc; c_cy = cy; c_opnd = opnd;
        m_left = ((c_op == 5 || c_op == 6) ? 2 * MC : MC) - 1;
      end
    end
  end

  function automatic string tag_of(int o);
    case (o)
      0: return "R1"; 1: return "R2"; 2, 3: return "R3"; 4: return "R5";
      5: return "R6"; 6: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison, done timing R9 and hold R10
  task automatic compare();
    string t;
    t = m_done ? tag_of(c_op) : "R10";
    check(m_done ? "R9" : "R10", int'(done_o), int'(m_done));
    check(t, int'(acc_o), int'(m_acc));
    check(t, int'(opnd_o), int'(m_opnd));
    check((m_done && c_op inside {0, 1, 4}) ? "R4" : t, int'(cy_o), int'(m_cy));
  endtask

  task automatic issue(int o, bit [7:0] a, bit c, bit [7:0] d, int gap);
    op = 3'(o); acc = a; cy = c; opnd = d; start = 1'b1;
    @(negedge clk); compare();
    start = 1'b0;
    for (int i = 0; i < gap; i++) begin
      // R11: scrambled inputs with start while busy must not disturb the op
      if (i == 0) begin start = 1'b1; op = 3'(o ^ 1); acc = ~a; opnd = ~d; end
      else start = 1'b0;
      @(negedge clk); compare();
    end
    start = 1'b0;
  endtask

  initial begin
    #20000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12: reset state
    check("R12", int'(acc_o), 0); check("R12", int'(opnd_o), 0);
    check("R12", int'(cy_o), 0);  check("R12", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk); compare();
    issue(0, 8'h80, 1'b0, 8'h11, 2 * MC + 2);   // R1 top bit wraps
    issue(1, 8'h01, 1'b1, 8'h22, 2 * MC + 2);   // R2 low bit wraps, R4 carry kept
    issue(2, 8'h80, 1'b1, 8'h33, 2 * MC + 2);   // R3
    issue(3, 8'h01, 1'b0, 8'h44, 2 * MC + 2);   // R3
    issue(4, 8'hA5, 1'b1, 8'h55, 2 * MC + 2);   // R5
    issue(5, 8'h3C, 1'b1, 8'hC3, 3 * MC + 2);   // R6
    issue(6, 8'h12, 1'b0, 8'hAB, 3 * MC + 2);   // R7
    issue(7, 8'h9E, 1'b1, 8'h61, 2 * MC + 2);   // R8
    issue(5, 8'hFF, 1'b0, 8'h00, 2 * MC);       // R9 back-to-back boundary
    issue(0, 8'h7F, 1'b1, 8'hFE, MC);
    for (int k = 0; k < 4000; k++) begin
      start = 1'($urandom_range(0, 1));
      op    = 3'($urandom_range(0, 7));
      acc   = 8'($urandom);
      opnd  = 8'($urandom);
      cy    = 1'($urandom_range(0, 1));
      @(negedge clk); compare();
    end
    start = 1'b0;
    for (int k = 0; k < 3 * MC; k++) begin @(negedge clk); compare(); end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule